// File: doc/BRIEF.md
# Instruction-Loaded Countdown Timer Interrupt

This block is a one-shot countdown timer that a processor core reprograms by executing a custom timer instruction. The instruction decoder presents the source-register value of that instruction as load data together with a single-cycle load strobe. The timer copies this value into its counter. While the count is nonzero, it falls by one on every clock cycle.

When the count steps from one to zero, the block sets a pending interrupt flag toward the interrupt controller. The flag stays set until the controller acknowledges it. A count of zero means the timer is idle, so loading zero switches the timer off. Masking of the timer source is done outside the block. The current count is brought out for debug.

The whole timer exists only when the build-time parameter `TIMER_EN` is set; it defaults to off. With the parameter clear, both outputs are tied to zero.

Top module: `cd_timer_irq`

## Requirements
- R1: A synchronous active-high reset clears the count to 0 and the pending flag to 0.
- R2: When `load_en` is 1 at a clock edge, `count` equals `load_val` after that edge, whatever the count was before.
- R3: When `load_en` is 0 and `count` is nonzero at a clock edge, `count` after that edge is one less. This includes a start value of 32'hFFFF_FFFF.
- R4: `irq_pend` becomes 1 at the same edge where `count` steps from 1 to 0 without a load. `irq_pend` never rises at any other edge.
- R5: A count of zero with no load stays at zero and does not set `irq_pend`. Loading 0 therefore disables the timer.
- R6: Once set, `irq_pend` stays 1 until an edge where `irq_ack` is 1. If that edge carries no expiry, `irq_pend` reads 0 after it.
- R7: If `irq_ack` is 1 at the same edge as an expiry, `irq_pend` is 1 after that edge.
- R8: A load at an edge where `count` is 1 replaces the count with `load_val` and raises no interrupt.
- R9: After an expiry the count remains 0 on every later edge until the next load (one-shot).
- R10: With `TIMER_EN` = 0, `count` and `irq_pend` are 0 at all times, whatever the inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| load_en | input | 1 | One-cycle strobe from the timer instruction |
| load_val | input | W (32) | Source-register value to load |
| irq_ack | input | 1 | Acknowledge from the interrupt controller |
| irq_pend | output | 1 | Timer interrupt pending |
| count | output | W (32) | Current count, for debug |

## Verification
Every result is due one clock edge after the stimulus that causes it, because `count` and `irq_pend` are both single registers. A loaded value N therefore produces the interrupt N edges after the load edge. The bench drives inputs on the falling edge and samples the outputs 1 ns after the next rising edge. Each step's expected count and flag are compared in that single cycle. This keeps every comparison inside the cycle where the result first appears and before the next stimulus. The corner cases (acknowledge at expiry, load at count 1, reload of zero) are placed on exactly the edge where they collide.

// File: rtl/cd_timer_irq.sv
module cd_timer_irq #(
  parameter int W        = 32,
  parameter bit TIMER_EN = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_en,
  input  logic [W-1:0] load_val,
  input  logic         irq_ack,
  output logic         irq_pend,
  output logic [W-1:0] count
);

  localparam logic [W-1:0] ONE = W'(1);

  generate
    if (TIMER_EN) begin : g_on
      logic [W-1:0] cnt_q;
      logic         pend_q;
      logic         expire;

      assign expire = !load_en && (cnt_q == ONE);

      always_ff @(posedge clk) begin
        if (rst) begin
          cnt_q  <= '0;
          pend_q <= 1'b0;
        end else begin
          if (load_en)
            cnt_q <= load_val;
          else if (cnt_q != '0)
            cnt_q <= cnt_q - ONE;

          if (expire)
            pend_q <= 1'b1;
          else if (irq_ack)
            pend_q <= 1'b0;
        end
      end

      assign count    = cnt_q;
      assign irq_pend = pend_q;
    end else begin : g_off
      assign count    = '0;
      assign irq_pend = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/cd_timer_irq_chk.sv
module cd_timer_irq_chk #(
  parameter int W        = 32,
  parameter bit TIMER_EN = 1'b0
) (
  input logic         clk,
  input logic         rst,
  input logic         load_en,
  input logic [W-1:0] load_val,
  input logic         irq_ack,
  input logic         irq_pend,
  input logic [W-1:0] count
);

  localparam logic [W-1:0] ONE = W'(1);

  generate
    if (TIMER_EN) begin : g_on
      // R2
      load_takes_chk: assert property (@(posedge clk) disable iff (rst)
        load_en |=> count == $past(load_val));

      // R3
      step_down_chk: assert property (@(posedge clk) disable iff (rst)
        (!load_en && count != '0) |=> count == $past(count) - ONE);

      // R4
      fire_on_one_chk: assert property (@(posedge clk) disable iff (rst)
        (!load_en && count == ONE) |=> irq_pend);

      // R5
      idle_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (!load_en && count == '0) |=> count == '0);

      // R6
      ack_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_pend && irq_ack && !(!load_en && count == ONE)) |=> !irq_pend);

      // R8
      load_no_fire_chk: assert property (@(posedge clk) disable iff (rst)
        (load_en && !irq_pend) |=> !irq_pend);
    end else begin : g_off
      // R10
      absent_quiet_chk: assert property (@(posedge clk)
        count == '0 && !irq_pend);
    end
  endgenerate

endmodule

bind cd_timer_irq cd_timer_irq_chk #(.W(W), .TIMER_EN(TIMER_EN)) u_chk (
  .clk(clk), .rst(rst), .load_en(load_en), .load_val(load_val),
  .irq_ack(irq_ack), .irq_pend(irq_pend), .count(count)
);

// File: tb/test_cd_timer_irq.sv
module test_cd_timer_irq;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        load_en = 1'b0;
  logic [31:0] load_val = '0;
  logic        irq_ack = 1'b0;
  logic        irq_pend, irq_pend_off;
  logic [31:0] count, count_off;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  cd_timer_irq #(.W(32), .TIMER_EN(1'b1)) i_cd_timer_irq (
    .clk(clk), .rst(rst), .load_en(load_en), .load_val(load_val),
    .irq_ack(irq_ack), .irq_pend(irq_pend), .count(count)
  );

  cd_timer_irq #(.W(32), .TIMER_EN(1'b0)) i_cd_timer_irq_off (
    .clk(clk), .rst(rst), .load_en(load_en), .load_val(load_val),
    .irq_ack(irq_ack), .irq_pend(irq_pend_off), .count(count_off)
  );

  localparam int N = 16;
  localparam logic        V_LD  [N] = '{1,0,0,0,0,0,0,1,0,0,1,0,1,1,1,0};
  localparam logic [31:0] V_VAL [N] = '{3,0,0,0,0,0,0,2,0,0,0,0,1,5,7,0};
  localparam logic        V_ACK [N] = '{0,0,0,0,0,1,0,0,0,1,1,0,0,0,0,0};
  localparam logic [31:0] E_CNT [N] = '{3,2,1,0,0,0,0,2,1,0,0,0,1,5,7,6};
  localparam logic        E_PND [N] = '{0,0,0,1,1,0,0,0,0,1,0,0,0,0,0,0};
  localparam string       V_REQ [N] = '{"R2","R3","R3","R4","R6","R6","R9","R2",
                                        "R3","R7","R5","R5","R2","R8","R2","R3"};

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(logic ld, logic [31:0] val, logic ack);
    @(negedge clk);
    load_en  = ld;
    load_val = val;
    irq_ack  = ack;
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual running expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1
    check("R1 count", count, 32'h0);
    check("R1 pend", {31'b0, irq_pend}, 32'h0);
    @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < N; i++) begin
      step(V_LD[i], V_VAL[i], V_ACK[i]);
      check({V_REQ[i], " count"}, count, E_CNT[i]);
      check({V_REQ[i], " pend"}, {31'b0, irq_pend}, {31'b0, E_PND[i]});
    end

    // R3 top value wraps down, not over
    step(1'b1, 32'hFFFF_FFFF, 1'b0);
    check("R2 max load", count, 32'hFFFF_FFFF);
    step(1'b0, 32'h0, 1'b0);
    check("R3 max step", count, 32'hFFFF_FFFE);

    // R1 reset mid count clears state
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    check("R1 midrun count", count, 32'h0);
    @(negedge clk);
    rst = 1'b0;

    // R6 ack without pending keeps flag low; R9 one-shot over a long idle
    step(1'b1, 32'd2, 1'b0);
    step(1'b0, 32'd0, 1'b0);
    step(1'b0, 32'd0, 1'b0);
    check("R4 fire", {31'b0, irq_pend}, 32'h1);
    for (int k = 0; k < 10; k++) step(1'b0, 32'd0, 1'b0);
    check("R9 stays zero", count, 32'h0);
    check("R6 still pending", {31'b0, irq_pend}, 32'h1);
    step(1'b0, 32'd0, 1'b1);
    check("R6 cleared", {31'b0, irq_pend}, 32'h0);
    step(1'b0, 32'd0, 1'b1);
    check("R5 idle no fire", {31'b0, irq_pend}, 32'h0);

    // R10 absent timer stays quiet
    check("R10 count", count_off, 32'h0);
    check("R10 pend", {31'b0, irq_pend_off}, 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule